// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR-style flash with a 32-bit data bus made of four byte lanes. After software has started a program or erase operation, a start request makes the poller read the device status in back-to-back pairs through a request/acknowledge read port. For each enabled lane it compares the toggle bit of the two reads and looks at that lane's timeout flag. It then ends the operation as passed or failed.

When a toggling lane shows its timeout flag, the poller reads one more confirmation pair before it decides. A lane that still toggles in that pair has failed. On any failure the poller writes a reset command through a write request/acknowledge port, so that the device goes back to array-read mode. A host-side limit on the number of read pairs stops the poller from waiting forever on a device that never settles. An abort input drops an operation part way through. The next start then always begins with a fresh first read pair.

Top module: `tog_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o and wr_req_o are all low.
- R2: A poll is a pair of reads. For each read, rd_req_o stays high until a cycle with rd_ack_i high, and rd_data_i is captured in that cycle. A lane toggles when bit 6 of its byte (bits 6, 14, 22, 30 of the word) differs between the two reads. All other bits, including bit 7, are ignored.
- R3: When no enabled lane toggles within a pair, the operation ends with pass_o high. It ends after exactly the number of pairs read up to that point.
- R4: When enabled lanes toggle but none of them has its timeout flag high in the second read of the pair, another pair is read. The flag is bit 5 of each byte (bits 5, 13, 21, 29).
- R5: When a toggling enabled lane has its timeout flag high, one confirmation pair is read. A lane that was flagged and still toggles in that pair fails. If no flagged lane toggles, the result is a pass when no enabled lane toggles, and otherwise normal polling resumes.
- R6: On a failure, fail_lanes_o holds the failed lanes, with bit n standing for byte lane n. wr_req_o then stays high with wr_data_o equal to RST_CMD (0xF0 in each byte by default) until wr_ack_i, and done_o follows the acknowledge.
- R7: Lanes that are low in lane_en_i (sampled at start) never cause a toggle, a flag or a failure. With no lane enabled, the operation passes after one pair.
- R8: When max_polls_i pairs (0 is treated as 1) have been read and the operation is still open, it ends with timeout_o high, pass_o low and fail_lanes_o zero, after the same reset command write.
- R9: done_o is a one-cycle pulse with busy_o low. pass_o, timeout_o and fail_lanes_o hold their values until the next start. start_i is ignored while busy_o is high.
- R10: abort_i while busy returns the block to idle within one cycle, with no done_o pulse and no write. The next start begins from a first read pair, with no confirmation state kept from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (ignored while busy) |
| abort_i | input | 1 | Abandon the current poll |
| lane_en_i | input | 4 | Byte lanes to check |
| max_polls_i | input | CNT_W | Maximum number of read pairs |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Status read data |
| wr_req_o | output | 1 | Reset command write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | 32 | Reset command word |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully |
| timeout_o | output | 1 | Pair limit reached |
| fail_lanes_o | output | 4 | Lanes that failed |

## Verification
A behavioural flash model gives each lane its own read index at which toggling stops and its own index at which the timeout flag rises. Bit 7 and the low bits change on every read, so a compare on the wrong bit shows up at once. Directed cases separate each exit of the decision tree: an immediate stop, a late stop behind a raised flag (confirmation pass), a stuck lane (failure with a mask and a reset write), a disabled stuck lane, and the pair limit. Random lane enables, stop points, flag points and limits then mix these paths across lanes. The read count at done tells apart designs that take the right decision after the wrong number of pairs. An abort placed just after a flagged pair, followed by a clean operation, shows whether any confirmation state survives.

// File: rtl/tog_poll_pkg.sv
package tog_poll_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int TOG_BIT = 6;
  localparam int FLG_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_RD2, ST_EVAL, ST_WR
  } poll_st_e;

  typedef enum logic [1:0] {
    EV_MORE, EV_PASS, EV_FAIL, EV_WDOG
  } eval_e;
endpackage

// File: rtl/tog_lane_eval.sv
module tog_lane_eval (
  input  logic en_i,
  input  logic tog_a_i,
  input  logic tog_b_i,
  input  logic flg_i,
  output logic tog_o,
  output logic flg_o
);
  assign tog_o = en_i & (tog_a_i ^ tog_b_i);
  assign flg_o = en_i & flg_i;
endmodule

// File: rtl/tog_poll_wdog.sv
module tog_poll_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             last_o
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(1);
    end else if (clr_i) begin
      cnt_q <= '0;
      lim_q <= (max_i == '0) ? CNT_W'(1) : max_i;
    end else if (inc_i && !last_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // this pair completes the allowed budget
  assign last_o = ({1'b0, cnt_q} + EW'(1)) >= {1'b0, lim_q};

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_q);
endmodule

// File: rtl/tog_poll_fsm.sv
module tog_poll_fsm
  import tog_poll_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic             rd_ack_i,
  input  logic [LANES-1:0] rd_tog_i,
  input  logic [LANES-1:0] rd_flg_i,
  input  logic [LANES-1:0] tog_v_i,
  input  logic [LANES-1:0] flg_v_i,
  input  logic             wd_last_i,
  input  logic             wr_ack_i,
  output logic [LANES-1:0] en_o,
  output logic [LANES-1:0] t1_o,
  output logic [LANES-1:0] t2_o,
  output logic [LANES-1:0] f2_o,
  output logic             wd_clr_o,
  output logic             wd_inc_o,
  output logic             rd_req_o,
  output logic             wr_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             timeout_o,
  output logic [LANES-1:0] fail_o
);
  poll_st_e         st_q;
  eval_e            ev;
  logic             conf_q, done_q, pass_q, tmo_q;
  logic [LANES-1:0] en_q, seen_q, fmask_q, t1_q, t2_q, f2_q, fail_v;

  always_comb begin
    ev     = EV_MORE;
    fail_v = tog_v_i & seen_q;
    if (!conf_q) begin
      if (tog_v_i == '0) ev = EV_PASS;
    end else begin
      if (fail_v != '0)       ev = EV_FAIL;
      else if (tog_v_i == '0) ev = EV_PASS;
    end
    if (ev == EV_MORE && wd_last_i) ev = EV_WDOG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      conf_q  <= 1'b0;
      seen_q  <= '0;
      en_q    <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      f2_q    <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      tmo_q   <= 1'b0;
      fmask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i && st_q != ST_IDLE) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            en_q    <= lane_en_i;
            conf_q  <= 1'b0;
            seen_q  <= '0;
            pass_q  <= 1'b0;
            tmo_q   <= 1'b0;
            fmask_q <= '0;
            st_q    <= ST_RD1;
          end
          ST_RD1: if (rd_ack_i) begin
            t1_q <= rd_tog_i;
            st_q <= ST_RD2;
          end
          ST_RD2: if (rd_ack_i) begin
            t2_q <= rd_tog_i;
            f2_q <= rd_flg_i;
            st_q <= ST_EVAL;
          end
          ST_EVAL: begin
            unique case (ev)
              EV_PASS: begin
                pass_q <= 1'b1;
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end
              EV_FAIL: begin
                fmask_q <= fail_v;
                st_q    <= ST_WR;
              end
              EV_WDOG: begin
                tmo_q <= 1'b1;
                st_q  <= ST_WR;
              end
              default: begin
                // flagged toggling lanes arm a confirmation pair
                if (!conf_q && (tog_v_i & flg_v_i) != '0) begin
                  conf_q <= 1'b1;
                  seen_q <= tog_v_i & flg_v_i;
                end else begin
                  conf_q <= 1'b0;
                end
                st_q <= ST_RD1;
              end
            endcase
          end
          ST_WR: if (wr_ack_i) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign en_o      = en_q;
  assign t1_o      = t1_q;
  assign t2_o      = t2_q;
  assign f2_o      = f2_q;
  assign wd_clr_o  = (st_q == ST_IDLE) && start_i;
  assign wd_inc_o  = (st_q == ST_EVAL) && !abort_i;
  assign rd_req_o  = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign wr_req_o  = (st_q == ST_WR);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign timeout_o = tmo_q;
  assign fail_o    = fmask_q;

  p_req_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_en_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(en_q));
  p_pass_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (fail_o == '0 && !timeout_o));
  p_mask_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o & ~en_q) == '0);
  p_wr_not_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (!pass_o && (timeout_o || fail_o != '0)));
endmodule

// File: rtl/tog_poll_ctrl.sv
module tog_poll_ctrl
  import tog_poll_pkg::*;
#(
  parameter int                CNT_W   = 16,
  parameter logic [DATA_W-1:0] RST_CMD = 32'hF0F0_F0F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  input  logic              wr_ack_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              timeout_o,
  output logic [LANES-1:0]  fail_lanes_o
);
  logic [LANES-1:0] rd_tog, rd_flg, en, t1, t2, f2, tog_v, flg_v;
  logic             wd_clr, wd_inc, wd_last;
  logic             unused_data;

  assign unused_data = ^rd_data_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_tog[l] = rd_data_i[l*LANE_W + TOG_BIT];
    assign rd_flg[l] = rd_data_i[l*LANE_W + FLG_BIT];
    tog_lane_eval i_eval (
      .en_i    (en[l]),
      .tog_a_i (t1[l]),
      .tog_b_i (t2[l]),
      .flg_i   (f2[l]),
      .tog_o   (tog_v[l]),
      .flg_o   (flg_v[l])
    );
  end

  tog_poll_wdog #(.CNT_W(CNT_W)) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wd_clr),
    .inc_i  (wd_inc),
    .max_i  (max_polls_i),
    .last_o (wd_last)
  );

  tog_poll_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .lane_en_i (lane_en_i),
    .rd_ack_i  (rd_ack_i),
    .rd_tog_i  (rd_tog),
    .rd_flg_i  (rd_flg),
    .tog_v_i   (tog_v),
    .flg_v_i   (flg_v),
    .wd_last_i (wd_last),
    .wr_ack_i  (wr_ack_i),
    .en_o      (en),
    .t1_o      (t1),
    .t2_o      (t2),
    .f2_o      (f2),
    .wd_clr_o  (wd_clr),
    .wd_inc_o  (wd_inc),
    .rd_req_o  (rd_req_o),
    .wr_req_o  (wr_req_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .timeout_o (timeout_o),
    .fail_o    (fail_lanes_o)
  );

  assign wr_data_o = wr_req_o ? RST_CMD : '0;
endmodule

// File: tb/test_tog_poll_ctrl.sv
module test_tog_poll_ctrl;
  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic          clk = 0, rst_n = 0;
  logic          start = 0, abort = 0, rd_ack = 0, wr_ack = 0;
  logic [3:0]    lane_en = 0;
  logic [CW-1:0] max_polls = 0;
  logic [31:0]   rd_data = 0;
  logic          rd_req, wr_req, busy, done, pass, tmo;
  logic [31:0]   wr_data;
  logic [3:0]    fail_lanes;

  int checks = 0, errors = 0;
  int stop_a[4], flg_a[4];
  int ridx = 0, wr_cnt = 0, lat = 0;
  logic [31:0] wr_last = 0;
  logic op_clr = 0;
  logic e_pass, e_tmo;
  logic [3:0] e_mask;
  int e_reads;

  tog_poll_ctrl #(.CNT_W(CW)) i_tog_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .lane_en_i(lane_en), .max_polls_i(max_polls),
    .rd_req_o(rd_req), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_ack_i(wr_ack), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .pass_o(pass), .timeout_o(tmo),
    .fail_lanes_o(fail_lanes));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mdata(int i);
    logic [31:0] d = '0;
    for (int l = 0; l < 4; l++) begin
      int v = (i < stop_a[l]) ? i : stop_a[l];
      d[l*8+7] = i[0];
      d[l*8+6] = v[0];
      d[l*8+5] = (i >= flg_a[l]);
      d[l*8+0] = ~i[0];
      d[l*8+1] = i[1];
    end
    return d;
  endfunction

  // flash status model
  always @(posedge clk) begin
    rd_ack <= 0;
    wr_ack <= 0;
    if (op_clr) begin
      ridx <= 0; wr_cnt <= 0;
    end else begin
      if (rd_req && !rd_ack) begin
        if (lat == 0) begin
          rd_ack  <= 1;
          rd_data <= mdata(ridx);
          ridx    <= ridx + 1;
          lat     <= $urandom % 3;
        end else lat <= lat - 1;
      end
      if (wr_req && !wr_ack) begin
        wr_ack  <= 1;
        wr_cnt  <= wr_cnt + 1;
        wr_last <= wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void predict(input logic [3:0] en, input int mx);
    int i = 0, pairs = 0, m;
    logic conf = 0;
    logic [3:0] seen = 0, tg, fg, fm;
    m = (mx == 0) ? 1 : mx;
    e_pass = 0; e_tmo = 0; e_mask = 0;
    for (int k = 0; k < 100000; k++) begin
      for (int l = 0; l < 4; l++) begin
        tg[l] = en[l] && (i < stop_a[l]);
        fg[l] = en[l] && (i + 1 >= flg_a[l]);
      end
      pairs++; i += 2;
      if (!conf) begin
        if (tg == 0) begin e_pass = 1; break; end
        if ((tg & fg) != 0) begin seen = tg & fg; conf = 1; end
      end else begin
        fm = tg & seen;
        if (fm != 0) begin e_mask = fm; break; end
        if (tg == 0) begin e_pass = 1; break; end
        conf = 0;
      end
      if (pairs >= m) begin e_tmo = 1; break; end
    end
    e_reads = 2 * pairs;
  endfunction

  task automatic run_op(input logic [3:0] en, input int mx, input string tag, input bit poke);
    int cyc = 0;
    bit seen_done = 0;
    @(negedge clk); op_clr = 1;
    @(negedge clk); op_clr = 0;
    lane_en = en; max_polls = CW'(mx); start = 1;
    predict(en, mx);
    @(negedge clk); start = 0;
    while (!seen_done && cyc < 5000) begin
      if (poke && cyc == 3) begin start = 1; lane_en = ~en; max_polls = 1; end
      else start = 0;
      @(negedge clk); cyc++;
      if (done) seen_done = 1;
    end
    start = 0;
    chk(seen_done, {tag, " watchdog"}, cyc, 0);
    if (!seen_done) return;
    chk(!busy, "R9 busy low at done", busy, 0);
    chk(pass == e_pass, {tag, " pass"}, pass, e_pass);
    chk(tmo == e_tmo, "R8 timeout", tmo, e_tmo);
    chk(fail_lanes == e_mask, "R6 fail mask", fail_lanes, e_mask);
    chk(ridx == e_reads, "R2 read count", ridx, e_reads);
    chk(wr_cnt == ((e_pass) ? 0 : 1), "R6 reset write count", wr_cnt, e_pass ? 0 : 1);
    if (!e_pass) chk(wr_last == 32'hF0F0_F0F0, "R6 reset data", wr_last, 32'hF0F0_F0F0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(pass == e_pass && fail_lanes == e_mask, "R9 result held", pass, e_pass);
  endtask

  task automatic set_lanes(input int s0, s1, s2, s3, input int f0, f1, f2, f3);
    stop_a[0] = s0; stop_a[1] = s1; stop_a[2] = s2; stop_a[3] = s3;
    flg_a[0] = f0; flg_a[1] = f1; flg_a[2] = f2; flg_a[3] = f3;
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_lanes(0, 0, 0, 0, 999, 999, 999, 999);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_req, "R1 reset state",
        {busy, done, rd_req, wr_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_req, "R1 idle after reset", busy, 0);

    set_lanes(0, 0, 0, 0, 999, 999, 999, 999);
    run_op(4'hF, 8, "R3 immediate pass", 0);
    set_lanes(5, 2, 7, 0, 999, 999, 999, 999);
    run_op(4'hF, 20, "R4 repoll then pass", 0);
    set_lanes(3, 0, 0, 0, 0, 999, 999, 999);
    run_op(4'hF, 20, "R5 confirm pass", 0);
    set_lanes(100, 0, 100, 0, 999, 999, 4, 999);
    run_op(4'hF, 50, "R5 stuck lane fail", 0);
    set_lanes(100, 100, 0, 0, 0, 0, 999, 999);
    run_op(4'b0101, 50, "R7 disabled stuck lane", 0);
    run_op(4'b0000, 50, "R7 no lane enabled", 0);
    set_lanes(100, 100, 100, 100, 999, 999, 999, 999);
    run_op(4'hF, 5, "R8 pair limit", 0);
    run_op(4'hF, 0, "R8 zero limit", 0);
    set_lanes(9, 0, 0, 0, 999, 999, 999, 999);
    run_op(4'hF, 30, "R9 start ignored while busy", 1);

    // R10: abort just after a flagged pair, then a clean op
    set_lanes(100, 0, 0, 0, 0, 999, 999, 999);
    @(negedge clk); op_clr = 1;
    @(negedge clk); op_clr = 0;
    lane_en = 4'h1; max_polls = 100; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 200 && ridx < 2; c++) @(negedge clk);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(!busy && !rd_req, "R10 idle after abort", busy, 0);
    repeat (4) begin
      @(negedge clk);
      chk(!done && !wr_req, "R10 no done or write after abort", done, 0);
    end
    set_lanes(2, 0, 0, 0, 999, 999, 999, 999);
    run_op(4'h1, 20, "R10 restart from first pair", 0);

    for (int n = 0; n < 40; n++) begin
      for (int l = 0; l < 4; l++) begin
        stop_a[l] = $urandom % 14;
        flg_a[l]  = ($urandom % 3 == 0) ? 999 : $urandom % 20;
      end
      run_op(4'($urandom), 1 + $urandom % 16, "R5 random mix", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    checks++; errors++;
    $display("FAIL R1 global watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule